// File: doc/BRIEF.md
# Vector Across-Lanes Add Reduction

This unit adds together all lanes of a 128-bit vector source and returns one scalar of the same lane width. A 2-bit element-size code and a full/half flag, both taken from an instruction encoding, choose the lane width and whether the whole vector or only its lower 64 bits take part. The sum wraps modulo the lane width: any carry out of the top lane bit is discarded.

The truncated sum is placed in the low bits of a 64-bit destination value and every bit above it is zero. Encodings that have no defined meaning raise an unallocated flag. When the flag is set the destination write enable stays low.

The result appears one clock after a valid request, together with an output valid. Between requests the destination value keeps its last contents.

Top module: `vec_add_reduce`

## Requirements
- R1: Element-size code 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes. Code 3 is unallocated.
- R2: With 8-bit lanes, 16 lanes are summed when full is 1 and 8 lanes when full is 0.
- R3: With 16-bit lanes, 8 lanes are summed when full is 1 and 4 lanes when full is 0.
- R4: With 32-bit lanes and full set to 1, all 4 lanes are summed.
- R5: The sum wraps modulo 2^width, where width is the lane width. For example, sixteen 8-bit lanes of 0xFF give 0xF0.
- R6: The wrapped sum sits in the low bits of the 64-bit destination value. All bits above the lane width are zero.
- R7: Outputs are registered. A request with inValid high at one rising edge produces outValid high after that edge. Without a request, outValid is low after the edge.
- R8: Size code 3, or size code 2 with full at 0, sets unallocFlag with wrEn low and a destination value of zero. Legal requests set wrEn with unallocFlag low.
- R9: Lane 0 is bits 7:0 (or 15:0, or 31:0) of the source, and lanes count upward from there. In half mode, source bits 127:64 have no effect on the result.
- R10: dstVal keeps its value in every cycle with no request, whatever the source input does.
- R11: After reset, outValid, wrEn and unallocFlag are 0 and dstVal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| sizeCode | input | 2 | Element-size code |
| fullWidth | input | 1 | 1: use 128-bit source, 0: use lower 64 bits |
| srcVec | input | 128 | Vector source |
| outValid | output | 1 | Result valid, one cycle after request |
| dstVal | output | 64 | Zero-filled, wrapped sum |
| wrEn | output | 1 | Destination write enable for legal requests |
| unallocFlag | output | 1 | Unallocated encoding was seen |

## Verification
Lane masking and wrap-around truncation can act in the same cycle. A half-width request whose lower lanes overflow the lane width, and whose upper 64 bits hold large values, exercises both. It is judged against a result that must both ignore the upper half and discard the carry. Legality detection can also coincide with the held-result behaviour. An illegal request must zero the destination, and the idle cycle after it must keep that zero while the source changes.

// File: rtl/vec_add_reduce_pkg.sv
package vec_add_reduce_pkg;
  typedef enum logic [1:0] {
    ELEM_B8   = 2'd0,
    ELEM_H16  = 2'd1,
    ELEM_W32  = 2'd2,
    ELEM_NONE = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      load;
    logic      illegal;
    logic      halfSrc;
    elemSize_e elem;
  } redCtrl_t;
endpackage

// File: rtl/vec_add_reduce_ctrl.sv
module vec_add_reduce_ctrl
  import vec_add_reduce_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] sizeCode,
  input  logic       fullWidth,
  output redCtrl_t   ctrl
);
  always_comb begin
    ctrl.load    = inValid;
    ctrl.halfSrc = !fullWidth;
    ctrl.elem    = elemSize_e'(sizeCode);
    // R1, R4, R8: code 3 never legal; 32-bit lanes only in full form
    ctrl.illegal = (sizeCode == 2'd3) || ((sizeCode == 2'd2) && !fullWidth);
  end
endmodule

// File: rtl/vec_add_reduce_datapath.sv
module vec_add_reduce_datapath
  import vec_add_reduce_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int DST_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  redCtrl_t         ctrl,
  input  logic [VEC_W-1:0] srcVec,
  output logic             outValid,
  output logic [DST_W-1:0] dstVal,
  output logic             wrEn,
  output logic             unallocFlag
);
  localparam int NUM_WIDTHS = 3;

  logic [DST_W-1:0] laneSum [NUM_WIDTHS];

  // One wrapping adder tree per lane width: 8, 16, 32 bits
  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    localparam int EW    = 8 << k;
    localparam int LANES = VEC_W / EW;
    logic [EW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < LANES; i++) begin
        if (!ctrl.halfSrc || (i < LANES / 2))
          acc = acc + srcVec[i*EW +: EW];
      end
    end
    assign laneSum[k] = {{(DST_W-EW){1'b0}}, acc};
  end

  logic [DST_W-1:0] pickSum;
  always_comb begin
    case (ctrl.elem)
      ELEM_B8:  pickSum = laneSum[0];
      ELEM_H16: pickSum = laneSum[1];
      ELEM_W32: pickSum = laneSum[2];
      default:  pickSum = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      wrEn        <= 1'b0;
      unallocFlag <= 1'b0;
      dstVal      <= '0;
    end else begin
      outValid    <= ctrl.load;
      wrEn        <= ctrl.load && !ctrl.illegal;
      unallocFlag <= ctrl.load && ctrl.illegal;
      if (ctrl.load)
        dstVal <= ctrl.illegal ? '0 : pickSum;
    end
  end

  assert_wren_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (!unallocFlag && outValid));
  assert_unalloc_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    unallocFlag |-> (dstVal == '0));
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> !outValid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(dstVal));
endmodule

// File: rtl/vec_add_reduce.sv
module vec_add_reduce
  import vec_add_reduce_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int DST_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       sizeCode,
  input  logic             fullWidth,
  input  logic [VEC_W-1:0] srcVec,
  output logic             outValid,
  output logic [DST_W-1:0] dstVal,
  output logic             wrEn,
  output logic             unallocFlag
);
  redCtrl_t ctrl;

  vec_add_reduce_ctrl u_ctrl (
    .inValid  (inValid),
    .sizeCode (sizeCode),
    .fullWidth(fullWidth),
    .ctrl     (ctrl)
  );

  vec_add_reduce_datapath #(.VEC_W(VEC_W), .DST_W(DST_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .srcVec     (srcVec),
    .outValid   (outValid),
    .dstVal     (dstVal),
    .wrEn       (wrEn),
    .unallocFlag(unallocFlag)
  );

  assert_zerofill8_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(sizeCode) == 2'd0) |-> (dstVal[DST_W-1:8] == '0));
  assert_zerofill16_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(sizeCode) == 2'd1) |-> (dstVal[DST_W-1:16] == '0));
  assert_zerofill32_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(sizeCode) == 2'd2) |-> (dstVal[DST_W-1:32] == '0));
endmodule

// File: tb/vec_add_reduce_tb.sv
module vec_add_reduce_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   sizeCode = 2'd0;
  logic         fullWidth = 1'b0;
  logic [127:0] srcVec = '0;
  logic         outValid, wrEn, unallocFlag;
  logic [63:0]  dstVal;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  vec_add_reduce u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .fullWidth(fullWidth), .srcVec(srcVec), .outValid(outValid),
    .dstVal(dstVal), .wrEn(wrEn), .unallocFlag(unallocFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected wrapped sum from the requirements (R1-style lane counts per size)
  function automatic logic [63:0] refSum(input logic [1:0] sz, input logic full,
                                         input logic [127:0] v);
    int ew = 8 << sz;
    int n = (128 / ew) / (full ? 1 : 2);
    logic [63:0] mask = (64'd1 << ew) - 64'd1;
    logic [63:0] s = '0;
    for (int i = 0; i < n; i++) s = s + ((v >> (i * ew)) & {64'd0, mask});
    return s & mask;
  endfunction

  task automatic runOp(input string tag, input logic [1:0] sz, input logic full,
                       input logic [127:0] v, input logic expIllegal,
                       input logic [63:0] expVal);
    @(negedge clk);
    inValid = 1'b1; sizeCode = sz; fullWidth = full; srcVec = v;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R7 outValid"}, {63'd0, outValid}, 64'd1);
    check({tag, " R8 unallocFlag"}, {63'd0, unallocFlag}, {63'd0, expIllegal});
    check({tag, " R8 wrEn"}, {63'd0, wrEn}, {63'd0, !expIllegal});
    check({tag, " dstVal"}, dstVal, expIllegal ? 64'd0 : expVal);
  endtask

  task automatic testReset();
    check("R11 outValid", {63'd0, outValid}, 64'd0);
    check("R11 wrEn", {63'd0, wrEn}, 64'd0);
    check("R11 unallocFlag", {63'd0, unallocFlag}, 64'd0);
    check("R11 dstVal", dstVal, 64'd0);
  endtask

  task automatic testBytes();
    logic [127:0] v = 128'hf8f9fafb_fcfdfeff_08070605_04030201;
    runOp("R2 R1 byte full", 2'd0, 1'b1, v, 1'b0, refSum(2'd0, 1'b1, v));
    runOp("R2 R9 byte half", 2'd0, 1'b0, v, 1'b0, 64'd36);
    runOp("R5 R6 byte wrap", 2'd0, 1'b1, {128{1'b1}}, 1'b0, 64'h00f0);
  endtask

  task automatic testHalves();
    logic [127:0] v = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    runOp("R3 half16 full", 2'd1, 1'b1, v, 1'b0, refSum(2'd1, 1'b1, v));
    runOp("R3 half16 half", 2'd1, 1'b0, v, 1'b0, refSum(2'd1, 1'b0, v));
    runOp("R5 R6 half16 wrap", 2'd1, 1'b1, {128{1'b1}}, 1'b0, 64'hfff8);
  endtask

  task automatic testWords();
    logic [127:0] v = 128'h80000000_7fffffff_00000010_00000005;
    runOp("R4 word full", 2'd2, 1'b1, v, 1'b0, refSum(2'd2, 1'b1, v));
    runOp("R5 R6 word wrap", 2'd2, 1'b1, {128{1'b1}}, 1'b0, 64'hfffffffc);
  endtask

  task automatic testLaneOrderMix();
    // R9 + R5 together: upper half junk, lower 8 lanes 0x40 overflow to 0
    logic [127:0] v = {64'hffff_ffff_ffff_ffff, {8{8'h40}}};
    runOp("R9 R5 half mask+wrap", 2'd0, 1'b0, v, 1'b0, 64'h00);
    runOp("R9 lane0 only", 2'd2, 1'b1, 128'h0000002a, 1'b0, 64'h2a);
  endtask

  task automatic testIllegal();
    logic [63:0] held;
    runOp("R8 R1 size3", 2'd3, 1'b1, {128{1'b1}}, 1'b1, 64'd0);
    runOp("R8 word half", 2'd2, 1'b0, {128{1'b1}}, 1'b1, 64'd0);
    held = dstVal;
    srcVec = 128'h1234;
    @(negedge clk);
    check("R10 hold after illegal", dstVal, held);
    check("R7 idle outValid", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testHold();
    logic [63:0] held;
    runOp("R10 setup", 2'd0, 1'b1, 128'h0102, 1'b0, 64'h03);
    held = dstVal;
    sizeCode = 2'd1; fullWidth = 1'b1; srcVec = {128{1'b1}};
    @(negedge clk);
    check("R10 hold no request", dstVal, held);
    @(negedge clk);
    check("R10 hold second idle", dstVal, held);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBytes();
    testHalves();
    testWords();
    testLaneOrderMix();
    testIllegal();
    testHold();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule